// File: doc/BRIEF.md
# Flash Page Program Controller with Suspend and Resume

This block takes keyed commands and drives the page program flow of a small behavioural flash array. A command has a key, an opcode and a target page. The controller checks the key and the lock state of the page's region. It then runs a program whose length is set in clock cycles. At the end of that time the staged latch data is ANDed into the page, and a verify pass checks that every bit meant to be cleared really is zero. Software, or a bus adapter, fills the per-page latch one word at a time before it issues the command. The latch returns to all ones when each program completes.

A program that is running can be paused so that the array can be read, and later continued. A pause request near the end of the program is ignored and the program simply finishes. A pause request that comes too soon after a continue is also ignored. The locking form of the program command locks the whole region when the program succeeds. Locks stay set until reset.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset: `ready` is 1; `suspended`, `cmdErr`, `lockErr`, `flashErr`, `irq` and `regionLocked` are 0; every array and latch word reads all ones.
- R2: A program command (opcode 00 plain, 01 locking) with the right key to an unlocked page while idle drops `ready` on the next cycle. `ready` returns exactly PROG_CYCLES+1 cycles after the command cycle. During that time `rdValid` stays low.
- R3: When `readyIrqEn` is 1, `irq` is a one-cycle pulse in the first cycle in which `ready` is high again. It never pulses while `ready` is steady.
- R4: A command whose key is not KEY sets `cmdErr` on the next cycle and starts nothing.
- R5: A program command to a page in a locked region sets `lockErr`, leaves `ready` high and leaves the array unchanged.
- R6: Programming sets each word of the target page to its old value AND the matching latch word, so it only clears bits. The latch then returns to all ones, and a program issued with no new latch writes leaves the page unchanged.
- R7: If the verify pass finds a bit that should have cleared but is still one, `flashErr` is set and the locking command does not lock the region. The `cellWeak` input models this fault by keeping bit 0 of word 0 from being cleared.
- R8: A successful locking program (opcode 01) sets the bit of `regionLocked` for page/PAGES_PER_REGION. The plain command (opcode 00) locks nothing. Lock bits never clear except on reset.
- R9: A suspend (opcode 10) that arrives while at least LATE_WIN program cycles remain sets `ready` and `suspended` together on the next cycle. Reads are then granted, and the page still holds its old data.
- R10: A suspend that arrives when fewer than LATE_WIN cycles remain is ignored. The program completes with `suspended` low.
- R11: A resume (opcode 11) while suspended clears `ready` and `suspended` on the next cycle. The program continues from where it stopped and ends with the programmed data.
- R12: A suspend that arrives fewer than RESUME_GAP cycles after a resume is ignored. One that arrives after the gap has passed is honoured.
- R13: These are rejected with `cmdErr`: a program command while busy or suspended, a resume while not suspended, and a suspend while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, one cycle |
| cmdKey | input | KEY_W | Command key, must equal KEY |
| cmdCode | input | 2 | Opcode: 00 program, 01 program and lock, 10 suspend, 11 resume |
| cmdPage | input | PAGE_AW | Target page of a program command |
| readyIrqEn | input | 1 | Enables the ready interrupt pulse |
| cellWeak | input | 1 | Fault model: bit 0 of word 0 resists programming |
| latchWe | input | 1 | Latch word write strobe |
| latchIdx | input | IDX_W | Latch word index |
| latchData | input | WORD_W | Latch word data |
| rdEn | input | 1 | Array read request |
| rdPage | input | PAGE_AW | Read page |
| rdIdx | input | IDX_W | Read word index |
| rdData | output | WORD_W | Array word at rdPage/rdIdx |
| rdValid | output | 1 | Read granted (not busy programming) |
| ready | output | 1 | Controller idle or suspended |
| suspended | output | 1 | Program paused |
| cmdErr | output | 1 | Bad key or command not allowed in this state |
| lockErr | output | 1 | Program target was locked |
| flashErr | output | 1 | Verify failed after program |
| irq | output | 1 | Ready interrupt pulse |
| regionLocked | output | NUM_REGIONS | Lock bit per region |

## Verification
The bench uses the default parameters: four pages of four 8-bit words, two pages per region, a 20-cycle program, a 4-cycle late window and a 6-cycle resume gap. These short values let one run fit a suspend, a suspend that is refused inside the gap, and a second suspend that is honoured, all within a single program. A late suspend lands inside the final four cycles. Two regions allow a region to be locked while the other remains free for the suspend and verify-fault cases.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

  typedef enum logic [1:0] {
    OP_WP   = 2'b00,
    OP_WPL  = 2'b01,
    OP_SUSP = 2'b10,
    OP_RES  = 2'b11
  } opcode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PROG,
    ST_SUSP,
    ST_VERIFY
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capPage;
    logic doProg;
    logic setLock;
    logic clrLatch;
  } dpCtrl_t;

endpackage

// File: rtl/flash_prog_dp.sv
module flash_prog_dp
  import flash_prog_pkg::*;
#(
  parameter int WORD_W           = 8,
  parameter int PAGE_WORDS       = 4,
  parameter int NUM_PAGES        = 4,
  parameter int PAGES_PER_REGION = 2,
  localparam int IDX_W       = $clog2(PAGE_WORDS),
  localparam int PAGE_AW     = $clog2(NUM_PAGES),
  localparam int NUM_REGIONS = NUM_PAGES / PAGES_PER_REGION
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpCtrl_t                ctrl,
  input  logic [PAGE_AW-1:0]     cmdPage,
  input  logic                   cellWeak,
  input  logic                   latchWe,
  input  logic [IDX_W-1:0]       latchIdx,
  input  logic [WORD_W-1:0]      latchData,
  input  logic [PAGE_AW-1:0]     rdPage,
  input  logic [IDX_W-1:0]       rdIdx,
  output logic [WORD_W-1:0]      rdData,
  output logic                   cmdPageLocked,
  output logic                   verifyOk,
  output logic [NUM_REGIONS-1:0] regionLocked
);

  localparam int REG_SHIFT = $clog2(PAGES_PER_REGION);
  localparam int REG_AW    = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

  logic [WORD_W-1:0]      mem   [NUM_PAGES][PAGE_WORDS];
  logic [WORD_W-1:0]      latch [PAGE_WORDS];
  logic [PAGE_AW-1:0]     tgtPage;
  logic [NUM_REGIONS-1:0] locks;
  logic [PAGE_WORDS-1:0]  wordBad;
  logic [WORD_W-1:0]      weakMask;
  logic [REG_AW-1:0]      tgtRegion;
  logic [REG_AW-1:0]      cmdRegion;

  assign weakMask  = {{(WORD_W-1){1'b0}}, cellWeak};
  assign tgtRegion = REG_AW'(tgtPage >> REG_SHIFT);
  assign cmdRegion = REG_AW'(cmdPage >> REG_SHIFT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_PAGES; p++)
        for (int w = 0; w < PAGE_WORDS; w++)
          mem[p][w] <= '1;
      for (int w = 0; w < PAGE_WORDS; w++)
        latch[w] <= '1;
      tgtPage <= '0;
      locks   <= '0;
    end else begin
      if (ctrl.capPage) tgtPage <= cmdPage;
      if (ctrl.clrLatch) begin
        for (int w = 0; w < PAGE_WORDS; w++)
          latch[w] <= '1;
      end else if (latchWe) begin
        latch[latchIdx] <= latchData;
      end
      if (ctrl.doProg) begin
        for (int w = 0; w < PAGE_WORDS; w++)
          mem[tgtPage][w] <= mem[tgtPage][w] &
                             (latch[w] | ((w == 0) ? weakMask : '0));
      end
      if (ctrl.setLock) locks[tgtRegion] <= 1'b1;
    end
  end

  // per-word verify: a zero in the latch must be a zero in the array
  for (genvar w = 0; w < PAGE_WORDS; w++) begin : g_verify
    assign wordBad[w] = |(mem[tgtPage][w] & ~latch[w]);
  end

  assign verifyOk      = ~|wordBad;
  assign rdData        = mem[rdPage][rdIdx];
  assign cmdPageLocked = locks[cmdRegion];
  assign regionLocked  = locks;

endmodule

// File: rtl/flash_prog_fsm.sv
module flash_prog_fsm
  import flash_prog_pkg::*;
#(
  parameter int PROG_CYCLES = 20,
  parameter int LATE_WIN    = 4,
  parameter int RESUME_GAP  = 6,
  parameter int KEY_W       = 8,
  parameter logic [KEY_W-1:0] KEY = 8'hA5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [KEY_W-1:0] cmdKey,
  input  logic [1:0]       cmdCode,
  input  logic             readyIrqEn,
  input  logic             cmdPageLocked,
  input  logic             verifyOk,
  input  logic             rdEn,
  output dpCtrl_t          ctrl,
  output logic             ready,
  output logic             suspended,
  output logic             cmdErr,
  output logic             lockErr,
  output logic             flashErr,
  output logic             irq,
  output logic             rdValid
);

  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam int GAP_W = $clog2(RESUME_GAP + 1);
  localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] LATE_V    = CNT_W'(LATE_WIN);
  localparam logic [GAP_W-1:0] GAP_V     = GAP_W'(RESUME_GAP);

  state_e           st, stNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic [GAP_W-1:0] gap, gapNext;
  logic             withLock, withLockNext;
  logic             errCmd, errLock, keyOk, isProg, readyNext;
  opcode_e          op;

  assign op     = opcode_e'(cmdCode);
  assign keyOk  = (cmdKey == KEY);
  assign isProg = (op == OP_WP) || (op == OP_WPL);

  always_comb begin
    stNext       = st;
    cntNext      = cnt;
    gapNext      = gap;
    withLockNext = withLock;
    ctrl         = '0;
    errCmd       = cmdValid && !keyOk;
    errLock      = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (cmdValid && keyOk) begin
          if (!isProg) errCmd = 1'b1;
          else if (cmdPageLocked) errLock = 1'b1;
          else begin
            stNext       = ST_PROG;
            cntNext      = PROG_LAST;
            gapNext      = '0;
            withLockNext = (op == OP_WPL);
            ctrl.capPage = 1'b1;
          end
        end
      end
      ST_PROG: begin
        if (cmdValid && keyOk && op != OP_SUSP) errCmd = 1'b1;
        if (cmdValid && keyOk && op == OP_SUSP && cnt >= LATE_V && gap == '0) begin
          stNext = ST_SUSP;
        end else begin
          if (gap != '0) gapNext = gap - 1'b1;
          if (cnt == '0) begin
            ctrl.doProg = 1'b1;
            stNext      = ST_VERIFY;
          end else begin
            cntNext = cnt - 1'b1;
          end
        end
      end
      ST_SUSP: begin
        if (cmdValid && keyOk) begin
          if (op == OP_RES) begin
            stNext  = ST_PROG;
            gapNext = GAP_V;
          end else begin
            errCmd = 1'b1;
          end
        end
      end
      ST_VERIFY: begin
        if (cmdValid && keyOk && op != OP_SUSP) errCmd = 1'b1;
        stNext        = ST_IDLE;
        ctrl.clrLatch = 1'b1;
        ctrl.setLock  = withLock && verifyOk;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  assign ready     = (st == ST_IDLE) || (st == ST_SUSP);
  assign suspended = (st == ST_SUSP);
  assign readyNext = (stNext == ST_IDLE) || (stNext == ST_SUSP);
  assign rdValid   = rdEn && ready;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      gap      <= '0;
      withLock <= 1'b0;
      cmdErr   <= 1'b0;
      lockErr  <= 1'b0;
      flashErr <= 1'b0;
      irq      <= 1'b0;
    end else begin
      st       <= stNext;
      cnt      <= cntNext;
      gap      <= gapNext;
      withLock <= withLockNext;
      irq      <= readyIrqEn && readyNext && !ready;
      if (cmdValid) begin
        cmdErr   <= errCmd;
        lockErr  <= errLock;
        flashErr <= 1'b0;
      end
      if (st == ST_VERIFY) flashErr <= !verifyOk;
    end
  end

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_prog_pkg::*;
#(
  parameter int WORD_W           = 8,
  parameter int PAGE_WORDS       = 4,
  parameter int NUM_PAGES        = 4,
  parameter int PAGES_PER_REGION = 2,
  parameter int PROG_CYCLES      = 20,
  parameter int LATE_WIN         = 4,
  parameter int RESUME_GAP       = 6,
  parameter int KEY_W            = 8,
  parameter logic [KEY_W-1:0] KEY = 8'hA5,
  localparam int IDX_W       = $clog2(PAGE_WORDS),
  localparam int PAGE_AW     = $clog2(NUM_PAGES),
  localparam int NUM_REGIONS = NUM_PAGES / PAGES_PER_REGION
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cmdValid,
  input  logic [KEY_W-1:0]       cmdKey,
  input  logic [1:0]             cmdCode,
  input  logic [PAGE_AW-1:0]     cmdPage,
  input  logic                   readyIrqEn,
  input  logic                   cellWeak,
  input  logic                   latchWe,
  input  logic [IDX_W-1:0]       latchIdx,
  input  logic [WORD_W-1:0]      latchData,
  input  logic                   rdEn,
  input  logic [PAGE_AW-1:0]     rdPage,
  input  logic [IDX_W-1:0]       rdIdx,
  output logic [WORD_W-1:0]      rdData,
  output logic                   rdValid,
  output logic                   ready,
  output logic                   suspended,
  output logic                   cmdErr,
  output logic                   lockErr,
  output logic                   flashErr,
  output logic                   irq,
  output logic [NUM_REGIONS-1:0] regionLocked
);

  dpCtrl_t dpCtrl;
  logic    cmdPageLocked;
  logic    verifyOk;

  flash_prog_fsm #(
    .PROG_CYCLES(PROG_CYCLES), .LATE_WIN(LATE_WIN), .RESUME_GAP(RESUME_GAP),
    .KEY_W(KEY_W), .KEY(KEY)
  ) fsm_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdKey(cmdKey), .cmdCode(cmdCode),
    .readyIrqEn(readyIrqEn), .cmdPageLocked(cmdPageLocked), .verifyOk(verifyOk),
    .rdEn(rdEn), .ctrl(dpCtrl), .ready(ready), .suspended(suspended),
    .cmdErr(cmdErr), .lockErr(lockErr), .flashErr(flashErr), .irq(irq),
    .rdValid(rdValid)
  );

  flash_prog_dp #(
    .WORD_W(WORD_W), .PAGE_WORDS(PAGE_WORDS), .NUM_PAGES(NUM_PAGES),
    .PAGES_PER_REGION(PAGES_PER_REGION)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(dpCtrl), .cmdPage(cmdPage), .cellWeak(cellWeak),
    .latchWe(latchWe), .latchIdx(latchIdx), .latchData(latchData),
    .rdPage(rdPage), .rdIdx(rdIdx), .rdData(rdData),
    .cmdPageLocked(cmdPageLocked), .verifyOk(verifyOk), .regionLocked(regionLocked)
  );

endmodule

// File: rtl/flash_prog_chk.sv
module flash_prog_chk #(
  parameter int PAGES_PER_REGION = 2,
  parameter int KEY_W            = 8,
  parameter logic [KEY_W-1:0] KEY = 8'hA5,
  parameter int PAGE_AW          = 2,
  parameter int NUM_REGIONS      = 2
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   cmdValid,
  input logic [KEY_W-1:0]       cmdKey,
  input logic [1:0]             cmdCode,
  input logic [PAGE_AW-1:0]     cmdPage,
  input logic                   ready,
  input logic                   suspended,
  input logic                   cmdErr,
  input logic                   lockErr,
  input logic                   irq,
  input logic [NUM_REGIONS-1:0] regionLocked
);

  localparam int REG_SHIFT = $clog2(PAGES_PER_REGION);
  localparam int REG_AW    = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

  logic [REG_AW-1:0] cmdRegion;
  logic              progReq;
  assign cmdRegion = REG_AW'(cmdPage >> REG_SHIFT);
  assign progReq   = cmdValid && cmdKey == KEY && !cmdCode[1] && ready && !suspended;

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    progReq && !regionLocked[cmdRegion] |=> !ready);

  // R3
  irq_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ready && !$past(ready));

  // R4
  bad_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdKey != KEY && ready && !suspended |=> cmdErr && ready);

  // R5
  lock_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    progReq && regionLocked[cmdRegion] |=> lockErr && ready);

  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regionLocked & $past(regionLocked)) == $past(regionLocked));

  // R9
  susp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    suspended && !(cmdValid && cmdKey == KEY && cmdCode == 2'b11) |=> suspended);

endmodule

bind flash_prog_ctrl flash_prog_chk #(
  .PAGES_PER_REGION(PAGES_PER_REGION), .KEY_W(KEY_W), .KEY(KEY),
  .PAGE_AW(PAGE_AW), .NUM_REGIONS(NUM_REGIONS)
) chk_i (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdKey(cmdKey), .cmdCode(cmdCode),
  .cmdPage(cmdPage), .ready(ready), .suspended(suspended), .cmdErr(cmdErr),
  .lockErr(lockErr), .irq(irq), .regionLocked(regionLocked)
);

// File: tb/flash_prog_ctrl_tb_top.sv
module flash_prog_ctrl_tb_top;

  localparam int PROG_CYCLES = 20;
  localparam logic [7:0] KEY = 8'hA5;
  localparam logic [1:0] C_WP = 2'b00, C_WPL = 2'b01, C_SUSP = 2'b10, C_RES = 2'b11;

  logic       clk = 1'b0, rstN = 1'b0;
  logic       cmdValid = 1'b0, readyIrqEn = 1'b0, cellWeak = 1'b0;
  logic [7:0] cmdKey = '0;
  logic [1:0] cmdCode = '0, cmdPage = '0, rdPage = '0, rdIdx = '0, latchIdx = '0;
  logic       latchWe = 1'b0, rdEn = 1'b0;
  logic [7:0] latchData = '0;
  logic [7:0] rdData;
  logic       rdValid, ready, suspended, cmdErr, lockErr, flashErr, irq;
  logic [1:0] regionLocked;

  flash_prog_ctrl dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdKey(cmdKey), .cmdCode(cmdCode),
    .cmdPage(cmdPage), .readyIrqEn(readyIrqEn), .cellWeak(cellWeak),
    .latchWe(latchWe), .latchIdx(latchIdx), .latchData(latchData),
    .rdEn(rdEn), .rdPage(rdPage), .rdIdx(rdIdx), .rdData(rdData), .rdValid(rdValid),
    .ready(ready), .suspended(suspended), .cmdErr(cmdErr), .lockErr(lockErr),
    .flashErr(flashErr), .irq(irq), .regionLocked(regionLocked)
  );

  always #10 clk = ~clk;

  int         nChecks = 0, nFails = 0, n;
  logic [7:0] model [4][4];
  logic [7:0] rv;

  // {page, pattern}; latch word w gets pattern ^ w
  localparam logic [9:0] VEC [4] = '{{2'd0, 8'hF0}, {2'd2, 8'h3C}, {2'd0, 8'hAA}, {2'd3, 8'h0F}};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doCmd(input logic [1:0] code, input logic [1:0] page, input logic [7:0] key);
    cmdValid = 1'b1; cmdCode = code; cmdPage = page; cmdKey = key;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic writeLatch(input logic [1:0] idx, input logic [7:0] data);
    latchWe = 1'b1; latchIdx = idx; latchData = data;
    @(negedge clk);
    latchWe = 1'b0;
  endtask

  task automatic waitReady();
    n = 0;
    while (!ready && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic readWord(input logic [1:0] page, input logic [1:0] idx);
    rdPage = page; rdIdx = idx;
    #1 rv = rdData;
  endtask

  task automatic checkPage(input logic [1:0] page, input string req);
    for (int w = 0; w < 4; w++) begin
      readWord(page, 2'(w));
      check(rv == model[page][w], req, rv, model[page][w]);
    end
  endtask

  initial begin
    #(20 * 100000);
    nFails++; nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    for (int p = 0; p < 4; p++)
      for (int w = 0; w < 4; w++)
        model[p][w] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(ready && !suspended && !cmdErr && !lockErr && !flashErr && !irq, "R1 flags",
          {ready, suspended, cmdErr, lockErr, flashErr, irq}, 6'b100000);
    check(regionLocked == 2'b00, "R1 locks", regionLocked, 0);
    checkPage(2'd1, "R1 array");

    // R6 vector table: AND programming
    for (int i = 0; i < 4; i++) begin
      logic [1:0] pg;
      logic [7:0] pat;
      {pg, pat} = VEC[i];
      for (int w = 0; w < 4; w++) begin
        writeLatch(2'(w), pat ^ 8'(w));
        model[pg][w] = model[pg][w] & (pat ^ 8'(w));
      end
      doCmd(C_WP, pg, KEY);
      waitReady();
      checkPage(pg, "R6 and-program");
    end
    check(regionLocked == 2'b00, "R8 plain no lock", regionLocked, 0);

    // R6 latch back to ones: program with no writes
    doCmd(C_WP, 2'd0, KEY);
    waitReady();
    checkPage(2'd0, "R6 latch reinit");

    // R2 R3 timing, irq, reads blocked
    readyIrqEn = 1'b1; rdEn = 1'b1;
    for (int w = 0; w < 4; w++) begin
      writeLatch(2'(w), 8'h77);
      model[1][w] = model[1][w] & 8'h77;
    end
    doCmd(C_WP, 2'd1, KEY);
    check(!ready, "R2 ready drop", ready, 0);
    check(!rdValid, "R2 read blocked", rdValid, 0);
    check(!irq, "R3 no irq busy", irq, 0);
    waitReady();
    check(n == PROG_CYCLES + 1, "R2 duration", n, PROG_CYCLES + 1);
    check(irq, "R3 irq pulse", irq, 1);
    @(negedge clk);
    check(!irq, "R3 irq one cycle", irq, 0);
    checkPage(2'd1, "R2 data");
    readyIrqEn = 1'b0; rdEn = 1'b0;

    // R13 program while busy
    doCmd(C_WP, 2'd1, KEY);
    @(negedge clk);
    doCmd(C_WP, 2'd1, KEY);
    check(cmdErr && !ready, "R13 busy reject", {cmdErr, ready}, 2'b10);
    waitReady();
    checkPage(2'd1, "R13 data intact");

    // R4 bad key
    writeLatch(2'd0, 8'h00);
    doCmd(C_WP, 2'd2, 8'h5A);
    check(cmdErr && ready, "R4 bad key", {cmdErr, ready}, 2'b11);
    @(negedge clk);
    check(ready, "R4 nothing started", ready, 1);
    doCmd(C_WP, 2'd0, KEY);   // consume latch on page 0
    model[0][0] = 8'h00;
    waitReady();

    // R8 locking program on page 0
    doCmd(C_WPL, 2'd0, KEY);
    waitReady();
    check(regionLocked == 2'b01, "R8 region locked", regionLocked, 1);

    // R5 page 1 shares region 0
    for (int w = 0; w < 4; w++) writeLatch(2'(w), 8'h00);
    doCmd(C_WP, 2'd1, KEY);
    check(lockErr && ready, "R5 lock error", {lockErr, ready}, 2'b11);
    checkPage(2'd1, "R5 unchanged");
    for (int w = 0; w < 4; w++) writeLatch(2'(w), 8'hFF);

    // R9 R11 R12 R13 suspend flow on page 2
    for (int w = 0; w < 4; w++) writeLatch(2'(w), 8'h81);
    doCmd(C_WP, 2'd2, KEY);
    repeat (2) @(negedge clk);
    doCmd(C_SUSP, 2'd0, KEY);
    check(ready && suspended, "R9 suspend", {ready, suspended}, 2'b11);
    rdEn = 1'b1;
    readWord(2'd2, 2'd0);
    check(rdValid, "R9 read granted", rdValid, 1);
    check(rv == model[2][0], "R9 old data", rv, model[2][0]);
    rdEn = 1'b0;
    doCmd(C_WP, 2'd2, KEY);
    check(cmdErr && suspended, "R13 prog while suspended", {cmdErr, suspended}, 2'b11);
    doCmd(C_RES, 2'd0, KEY);
    check(!ready && !suspended, "R11 resume", {ready, suspended}, 2'b00);
    doCmd(C_SUSP, 2'd0, KEY);
    check(!suspended && !ready, "R12 gap ignore", {ready, suspended}, 2'b00);
    repeat (7) @(negedge clk);
    doCmd(C_SUSP, 2'd0, KEY);
    check(suspended, "R12 after gap", suspended, 1);
    doCmd(C_RES, 2'd0, KEY);
    for (int w = 0; w < 4; w++) model[2][w] = model[2][w] & 8'h81;
    waitReady();
    check(!suspended, "R11 completed", suspended, 0);
    checkPage(2'd2, "R11 data");

    // R10 late suspend
    for (int w = 0; w < 4; w++) writeLatch(2'(w), 8'hC3);
    doCmd(C_WP, 2'd2, KEY);
    repeat (17) @(negedge clk);
    doCmd(C_SUSP, 2'd0, KEY);
    check(!suspended && !ready, "R10 late ignored", {ready, suspended}, 2'b00);
    for (int w = 0; w < 4; w++) model[2][w] = model[2][w] & 8'hC3;
    waitReady();
    check(!suspended, "R10 no suspend flag", suspended, 0);
    checkPage(2'd2, "R10 data");

    // R7 verify fault
    writeLatch(2'd0, 8'hFE);
    cellWeak = 1'b1;
    doCmd(C_WPL, 2'd3, KEY);
    waitReady();
    cellWeak = 1'b0;
    check(flashErr, "R7 flash error", flashErr, 1);
    check(regionLocked == 2'b01, "R7 no lock", regionLocked, 1);
    checkPage(2'd3, "R7 bit kept");

    // R13 idle suspend and resume
    doCmd(C_SUSP, 2'd0, KEY);
    check(cmdErr && !suspended, "R13 idle suspend", {cmdErr, suspended}, 2'b10);
    doCmd(C_RES, 2'd0, KEY);
    check(cmdErr && ready, "R13 idle resume", {cmdErr, ready}, 2'b11);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule